// File: doc/BRIEF.md
# Eight-Pin Register-Mapped GPIO Controller with Address-Masked Data Port

This block gives software eight general-purpose pins behind a simple APB-style slave. Each transfer has a setup phase and an access phase and no wait states. Every pin has three control bits: one picks its direction, one enables its interrupt, and one hands the pin over to an on-chip alternate function.

Pin levels are read and driven through a data window 256 words long. The word index inside that window acts as a per-bit mask. Software can therefore set, clear or sample any subset of pins in a single access, with no read-modify-write.

Pin inputs pass through a two-flop synchroniser before they are read or examined for interrupts. Each pin can be set to detect a rising edge, a falling edge, both edges, a high level or a low level. Latched edges are cleared by writing ones. The masked status bits are ORed together into one interrupt line.

Top module: `pinctl_apb`

## Requirements
- R1: After reset every register holds 0. So pad_oe is 0, irq is 0, and all control and status reads return 0.
- R2: A write at byte address {2'b00, m[7:0], 2'b00} updates data bit n to pwdata[n] only where m[n] is 1. Every other data bit keeps its value, and no other access changes the data register.
- R3: A read in the data window returns 0 in every bit whose mask bit is 0. Where the mask bit is 1, it returns the data register bit for an output pin, or the synchronised pin_in bit for an input pin.
- R4: Direction lives at 0x400, where 1 means output. With mode bit 0, pad_oe[n] follows direction bit n and pad_out[n] follows data bit n.
- R5: Mode lives at 0x420. With mode bit n at 1, pad_out[n] and pad_oe[n] come straight from alt_out[n] and alt_oe[n].
- R6: With sense bit n (0x404) at 0, raw status bit n (0x414) latches a rising edge of the synchronised input when event bit n (0x40C) is 1, and a falling edge when it is 0.
- R7: Both-edges bit n (0x408) at 1 latches either edge, whatever the event bit says.
- R8: With sense bit n at 1, raw status bit n equals the synchronised input when event bit n is 1, and its inverse when event bit n is 0. A clear write has no effect on that bit.
- R9: Writing 1 to bit n of the clear register (0x41C) clears a latched edge. Zero bits leave status unchanged, and the clear register reads 0.
- R10: Masked status (0x418) equals raw status AND enable (0x410). irq is 1 exactly when masked status is nonzero.
- R11: Reads of any other offset return 0, including unaligned ones, and writes to them change no register.
- R12: The direction, sense, both-edges, event, enable and mode registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write transfer |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Asynchronous pad inputs |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume a well-formed bus. A write only counts as a write in a cycle where psel, penable and pwrite are all high. Addresses and write data are known whenever psel is high, and presetn is asserted from time zero. The bench's bus tasks always run a clean setup phase followed by a one-cycle access phase. Random addresses are aligned, and pin inputs change away from the clock edge and are then held for several cycles, so the synchroniser settles before any read or status check.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int PINS = 8;

  typedef enum logic [7:0] {
    CW_DIR   = 8'h00,
    CW_SENSE = 8'h01,
    CW_BOTH  = 8'h02,
    CW_EVENT = 8'h03,
    CW_IE    = 8'h04,
    CW_RAW   = 8'h05,
    CW_MIS   = 8'h06,
    CW_CLR   = 8'h07,
    CW_MODE  = 8'h08
  } ctrl_word_e;
endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/pinctl_detect.sv
module pinctl_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_q, edge_d;
  logic [W-1:0] rise, fall, hit, lvl_hit, clr_mask;

  always_comb begin
    rise     = lvl_in & ~prev_q;
    fall     = ~lvl_in & prev_q;
    hit      = ~sense & ((both & (rise | fall)) |
                         (~both & ((evt & rise) | (~evt & fall))));
    clr_mask = clr_we ? clr_bits : '0;
    edge_d   = ~sense & ((edge_q & ~clr_mask) | hit);
    lvl_hit  = ~(lvl_in ^ evt);
    raw      = (sense & lvl_hit) | (~sense & edge_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= lvl_in;
      edge_q <= edge_d;
    end
  end
endmodule

// File: rtl/pinctl_apb.sv
module pinctl_apb
  import pinctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   pwdata,
  output logic [PINS-1:0]   prdata,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   alt_out,
  input  logic [PINS-1:0]   alt_oe,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);
  localparam int WIN_W = ADDR_W - 10;

  logic [WIN_W-1:0] win;
  logic [7:0]       word;
  logic             aligned, data_sel, ctrl_sel, wr_en, clr_we;

  logic [PINS-1:0] data_q, dir_q, sense_q, both_q, evt_q, ie_q, mode_q;
  logic [PINS-1:0] data_d, dir_d, sense_d, both_d, evt_d, ie_d, mode_d;
  logic [PINS-1:0] pin_s, raw, pin_view;

  assign win      = paddr[ADDR_W-1:10];
  assign word     = paddr[9:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign data_sel = aligned && (win == '0);
  assign ctrl_sel = aligned && (win == WIN_W'(1));
  assign wr_en    = psel && penable && pwrite;
  assign clr_we   = wr_en && ctrl_sel && (word == CW_CLR);

  pinctl_sync #(.W(PINS)) sync_i (
    .clk(pclk), .rst_n(presetn), .d_async(pin_in), .q_sync(pin_s)
  );

  pinctl_detect #(.W(PINS)) det_i (
    .clk(pclk), .rst_n(presetn), .lvl_in(pin_s), .sense(sense_q),
    .both(both_q), .evt(evt_q), .clr_we(clr_we), .clr_bits(pwdata),
    .raw(raw)
  );

  // next state of the software registers
  always_comb begin
    data_d  = data_q;
    dir_d   = dir_q;
    sense_d = sense_q;
    both_d  = both_q;
    evt_d   = evt_q;
    ie_d    = ie_q;
    mode_d  = mode_q;
    if (data_sel) begin
      data_d = (data_q & ~word) | (pwdata & word);
    end else if (ctrl_sel) begin
      case (word)
        CW_DIR:   dir_d   = pwdata;
        CW_SENSE: sense_d = pwdata;
        CW_BOTH:  both_d  = pwdata;
        CW_EVENT: evt_d   = pwdata;
        CW_IE:    ie_d    = pwdata;
        CW_MODE:  mode_d  = pwdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      ie_q    <= '0;
      mode_q  <= '0;
    end else if (wr_en) begin
      data_q  <= data_d;
      dir_q   <= dir_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      evt_q   <= evt_d;
      ie_q    <= ie_d;
      mode_q  <= mode_d;
    end
  end

  assign pin_view = (dir_q & data_q) | (~dir_q & pin_s);

  always_comb begin
    prdata = '0;
    if (data_sel) begin
      prdata = pin_view & word;
    end else if (ctrl_sel) begin
      case (word)
        CW_DIR:   prdata = dir_q;
        CW_SENSE: prdata = sense_q;
        CW_BOTH:  prdata = both_q;
        CW_EVENT: prdata = evt_q;
        CW_IE:    prdata = ie_q;
        CW_RAW:   prdata = raw;
        CW_MIS:   prdata = raw & ie_q;
        CW_MODE:  prdata = mode_q;
        default:  prdata = '0;
      endcase
    end
  end

  assign pad_out = (mode_q & alt_out) | (~mode_q & data_q);
  assign pad_oe  = (mode_q & alt_oe)  | (~mode_q & dir_q);
  assign irq     = |(raw & ie_q);
endmodule

// File: rtl/pinctl_apb_chk.sv
module pinctl_apb_chk
  import pinctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [PINS-1:0]   prdata,
  input logic [PINS-1:0]   alt_oe,
  input logic [PINS-1:0]   pad_oe,
  input logic              irq,
  input logic [PINS-1:0]   dir_q,
  input logic [PINS-1:0]   mode_q,
  input logic [PINS-1:0]   ie_q,
  input logic [PINS-1:0]   data_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge pclk)
    $rose(presetn) |-> (pad_oe == '0 && !irq));

  // R2
  data_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite && paddr[ADDR_W-1:10] == '0 && paddr[1:0] == 2'b00)
    |=> $stable(data_q));

  // R3
  unmasked_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && paddr[ADDR_W-1:10] == '0) |-> ((prdata & ~paddr[9:2]) == '0));

  // R4
  oe_source_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !$stable(pad_oe) |-> (!$stable(dir_q) || !$stable(mode_q) || !$stable(alt_oe)));

  // R10
  irq_needs_enable_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (ie_q == '0) |-> !irq);

  // R11
  hole_reads_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && (paddr[1:0] != 2'b00 || paddr[ADDR_W-1:10] > (ADDR_W-10)'(1) ||
     (paddr[ADDR_W-1:10] == (ADDR_W-10)'(1) && paddr[9:2] > 8'h08)))
    |-> (prdata == '0));
endmodule

bind pinctl_apb pinctl_apb_chk #(.ADDR_W(ADDR_W)) chk_i (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .alt_oe(alt_oe),
  .pad_oe(pad_oe), .irq(irq), .dir_q(dir_q), .mode_q(mode_q),
  .ie_q(ie_q), .data_q(data_q)
);

// File: tb/pinctl_apb_tb.sv
`timescale 1ns/1ps
module pinctl_apb_tb_top;
  localparam time CLK = 20ns;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata;
  logic [7:0]  pin_in = '0, alt_out = '0, alt_oe = '0;
  logic [7:0]  pad_out, pad_oe;
  logic        irq;

  int vecs = 0;
  int miss = 0;

  logic [7:0] m_data = '0, m_dir = '0, m_mode = '0, m_sense = '0;
  logic [7:0] m_both = '0, m_evt = '0, m_ie = '0;

  always #(CLK/2) pclk = ~pclk;

  pinctl_apb #(.ADDR_W(12)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [7:0] exp_view(input logic [7:0] mask);
    return ((m_dir & m_data) | (~m_dir & pin_in)) & mask;
  endfunction
  function automatic logic [7:0] exp_out();
    return (m_mode & alt_out) | (~m_mode & m_data);
  endfunction
  function automatic logic [7:0] exp_oe();
    return (m_mode & alt_oe) | (~m_mode & m_dir);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #5;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge pclk);
    pin_in = v;
    repeat (4) @(negedge pclk);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_pads(input string tag);
    chk({tag, " R4/R5 pad_out"}, pad_out, exp_out());
    chk({tag, " R4/R5 pad_oe"}, pad_oe, exp_oe());
    chk({tag, " R10 irq"}, {7'd0, irq}, {7'd0, |(8'h00)});
  endtask

  initial begin
    #(CLK * 150000);
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    repeat (2) @(negedge pclk);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd_chk("R1 dir", 12'h400, 8'h00);
    rd_chk("R1 mode", 12'h420, 8'h00);
    rd_chk("R1 raw", 12'h414, 8'h00);
    rd_chk("R1 data", 12'h3FC, 8'h00);

    // R2 directed: set a single bit, then clear another
    wr(12'h3FC, 8'hA5); m_data = 8'hA5;
    wr({2'b00, 8'h02, 2'b00}, 8'hFF); m_data = m_data | 8'h02;
    wr({2'b00, 8'h81, 2'b00}, 8'h00); m_data = m_data & 8'h7E;
    wr(12'h400, 8'hFF); m_dir = 8'hFF;
    chk("R2 single-bit writes pad_out", pad_out, 8'h26);
    rd_chk("R3 output readback", 12'h3FC, 8'h26);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] r, m;
      op = $urandom_range(0, 6);
      r  = 8'($urandom);
      m  = 8'($urandom);
      case (op)
        0: begin wr({2'b00, m, 2'b00}, r); m_data = (m_data & ~m) | (r & m); end
        1: begin wr(12'h400, r); m_dir = r; end
        2: begin wr(12'h420, r); m_mode = r; end
        3: rd_chk("R3 masked read", {2'b00, m, 2'b00}, exp_view(m));
        4: set_pins(r);
        5: begin @(negedge pclk); alt_out = r; alt_oe = m; @(negedge pclk); end
        default: begin
          case ($urandom_range(0, 2))
            0: begin wr(12'h404, r); m_sense = r; rd_chk("R12 sense", 12'h404, m_sense); end
            1: begin wr(12'h408, r); m_both = r; rd_chk("R12 both", 12'h408, m_both); end
            default: begin wr(12'h40C, r); m_evt = r; rd_chk("R12 event", 12'h40C, m_evt); end
          endcase
        end
      endcase
      chk_pads("rand");
      if (i % 40 == 0) begin
        rd_chk("R12 dir", 12'h400, m_dir);
        rd_chk("R12 mode", 12'h420, m_mode);
      end
    end

    // R11: holes and unaligned accesses
    wr(12'h424, 8'hFF);
    wr(12'h800, 8'hFF);
    wr(12'h401, 8'hFF);
    wr(12'h3FD, 8'hFF);
    rd_chk("R11 hole 0x424", 12'h424, 8'h00);
    rd_chk("R11 hole 0xC00", 12'hC00, 8'h00);
    rd_chk("R11 unaligned", 12'h3FE, 8'h00);
    rd_chk("R11 dir untouched", 12'h400, m_dir);
    rd_chk("R11 mode untouched", 12'h420, m_mode);
    chk("R11 data untouched", pad_out, exp_out());

    // interrupt setup: inputs, software mode, all edges
    wr(12'h420, 8'h00); m_mode = 0;
    wr(12'h400, 8'h00); m_dir = 0;
    wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h410, 8'h00);
    set_pins(8'h00);
    wr(12'h41C, 8'hFF);
    rd_chk("R9 clear reads zero", 12'h41C, 8'h00);
    rd_chk("R9 raw cleared", 12'h414, 8'h00);

    // R6 rising on pin0, falling on pin1
    wr(12'h40C, 8'h01);
    wr(12'h410, 8'h01); m_ie = 8'h01;
    rd_chk("R12 ie", 12'h410, 8'h01);
    set_pins(8'h01);
    rd_chk("R6 rising latched", 12'h414, 8'h01);
    rd_chk("R10 masked", 12'h418, 8'h01);
    chk("R10 irq high", {7'd0, irq}, 8'h01);
    set_pins(8'h00);
    rd_chk("R6 falling ignored on rising pin", 12'h414, 8'h01);
    wr(12'h41C, 8'h00);
    rd_chk("R9 zero clear no effect", 12'h414, 8'h01);
    wr(12'h41C, 8'h01);
    rd_chk("R9 clear one", 12'h414, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    set_pins(8'h02);
    rd_chk("R6 rising ignored on falling pin", 12'h414, 8'h00);
    set_pins(8'h00);
    rd_chk("R6 falling latched", 12'h414, 8'h02);
    rd_chk("R10 masked off", 12'h418, 8'h00);
    chk("R10 irq masked", {7'd0, irq}, 8'h00);
    wr(12'h41C, 8'hFF);

    // R7 both edges on pin2
    wr(12'h408, 8'h04);
    set_pins(8'h04);
    rd_chk("R7 rise", 12'h414, 8'h04);
    wr(12'h41C, 8'h04);
    set_pins(8'h00);
    rd_chk("R7 fall", 12'h414, 8'h04);
    wr(12'h41C, 8'hFF);
    wr(12'h408, 8'h00);

    // R8 level: pin3 high-level, pin4 low-level
    wr(12'h40C, 8'h08);
    wr(12'h404, 8'h18);
    repeat (2) @(negedge pclk);
    rd_chk("R8 level low pins", 12'h414, 8'h10);
    set_pins(8'h08);
    rd_chk("R8 level high pin3", 12'h414, 8'h18);
    wr(12'h41C, 8'h18);
    rd_chk("R8 clear no effect", 12'h414, 8'h18);
    wr(12'h410, 8'h08);
    chk("R10 irq level", {7'd0, irq}, 8'h01);
    set_pins(8'h18);
    rd_chk("R8 follows input", 12'h414, 8'h08);
    set_pins(8'h10);
    rd_chk("R8 drop", 12'h414, 8'h00);
    chk("R10 irq drop", {7'd0, irq}, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule